// File: doc/BRIEF.md
# Configuration Space Access Translator

This block converts a single configuration-space request into one aligned 32-bit access on a memory-mapped window. A request names a bus, device, function, register offset, byte count, direction and write data. The block picks Type 0 or Type 1 addressing from the bus number. It loads a window-select register through a one-cycle write strobe, then issues the access on a simple request/acknowledge backend port.

Reads return the addressed bytes, shifted down and zero-extended. A 1- or 2-byte write fetches the aligned word, replaces the addressed field and writes the whole word back. A 4-byte write goes out directly. Malformed requests are rejected without touching the window register or the backend. A backend bus error ends the request early with all-ones data.

Only one request is in flight at a time. `busy` frames the request, and a single-cycle `doneValid` carries the error code (0 ok, 1 invalid, 2 bus error) and the read data.

Top module: `cfg_xlate`

## Requirements
- R1: After reset, busy, doneValid, beReq and winSelWe are all 0.
- R2: On bus 0 with device 0..15, let onehot = 1 << (16 + device). The window-select value is 0x2 | (onehot & 0xFC000000). The access address is 0x0C000000 | (onehot & ~0xFC000000) | function << 8 | (offset & ~3).
- R3: On a non-zero bus, the window-select value is 0x3. The access address is 0x0C000000 | bus << 16 | device << 11 | function << 8 | (offset & ~3). Any 5-bit device number is accepted.
- R4: On bus 0, a device number of 16 or more completes with doneErr = 1, with no window write and no backend access.
- R5: With cardbusMode = 1, any device number other than 0 completes with doneErr = 1, with no window write and no backend access.
- R6: reqLen is a byte count. A count other than 1, 2 or 4, or a count of 2 with offset[1:0] = 3, completes with doneErr = 1 and no access. A count of 1 at offset[1:0] = 3 is legal.
- R7: A read makes exactly one backend read. doneRdata is the fetched word shifted right by 8 × offset[1:0], truncated to reqLen bytes and zero-extended, with doneErr = 0.
- R8: A 1- or 2-byte write makes a backend read and then a backend write to the same address. The written word equals the read word with its 8- or 16-bit field at byte lane offset[1:0] replaced by the low bytes of reqWdata.
- R9: A 4-byte write makes a single backend write of reqWdata and no read.
- R10: When beAck arrives with beErr = 1, the request completes with doneErr = 2 and doneRdata = 0xFFFFFFFF, and no further backend access is made for it.
- R11: busy rises in the cycle after reqValid is taken while idle. It stays high through a single-cycle doneValid and falls in the next cycle. reqValid while busy is ignored. doneRdata is 0 on writes and rejections.
- R12: The window register is written exactly once per accepted legal request, before its backend access. beReq stays high with stable address, direction and data until beAck. Every backend address is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Bus number |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOff | input | 8 | Register byte offset |
| reqLen | input | 3 | Byte count (1, 2 or 4 legal) |
| reqWdata | input | 32 | Write data, right-aligned |
| cardbusMode | input | 1 | Only device 0 reachable when set |
| busy | output | 1 | Request in progress |
| doneValid | output | 1 | Single-cycle completion pulse |
| doneErr | output | 2 | 0 ok, 1 invalid, 2 bus error |
| doneRdata | output | 32 | Read result, valid with doneValid |
| winSelWe | output | 1 | Window-select register write strobe |
| winSelData | output | 32 | Window-select value |
| beReq | output | 1 | Backend access request |
| beWrite | output | 1 | Backend access is a write |
| beAddr | output | 32 | Backend word address |
| beWdata | output | 32 | Backend write data |
| beAck | input | 1 | Backend access complete |
| beErr | input | 1 | Backend bus error, valid with beAck |
| beRdata | input | 32 | Backend read data, valid with beAck |

## Verification
The bound checker watches the handshake on every cycle. It checks that doneValid falls inside busy and lasts one cycle, that beReq holds stable until acknowledged, and that addresses are aligned. It also checks that the window strobe precedes any access, that rejected requests touch neither the window nor the backend, and that a bus error forces all-ones data and stops further accesses. Address composition for both transaction types, byte-lane extraction, read-modify-write merging and the rejection rules need known request values. These are shown only by the bench's scenarios, compared against a behavioural model of the window register and backend memory.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } cfgState_t;

  localparam logic [1:0] ERR_OK    = 2'd0;
  localparam logic [1:0] ERR_INVAL = 2'd1;
  localparam logic [1:0] ERR_BUS   = 2'd2;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // latch the incoming request
    logic loadWord;  // latch backend read data / error
    logic errFill;   // backend reported a bus error
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic invalid;   // request is rejected
    logic isWrite;   // captured direction
    logic fullWord;  // byte count equals the word width
  } dpStatus_t;

endpackage

// File: rtl/cfg_xlate_addr.sv
module cfg_xlate_addr #(
  parameter int ADDR_W    = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int OFF_W     = 8,
  parameter int BYTES     = 4,
  parameter int SLOT_MAX  = 16,
  parameter int IDSEL_POS = 16,
  parameter int BUS_POS   = 16,
  parameter int DEV_POS   = 11,
  parameter int FUNC_POS  = 8,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [ADDR_W-1:0] T0_CODE  = 32'h0000_0002,
  parameter logic [ADDR_W-1:0] T1_CODE  = 32'h0000_0003
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [OFF_W-1:0]  off,
  input  logic              cardbus,
  output logic              devBad,
  output logic [ADDR_W-1:0] winSel,
  output logic [ADDR_W-1:0] addr
);

  logic              isType0;
  logic [ADDR_W-1:0] idsel;
  logic [ADDR_W-1:0] offAligned;
  logic [ADDR_W-1:0] funcField;
  logic [ADDR_W-1:0] busField;
  logic [ADDR_W-1:0] devField;

  assign isType0    = (bus == '0);
  assign idsel      = ADDR_W'(1) << (IDSEL_POS + 32'(dev));
  assign offAligned = ADDR_W'(off) & ~ADDR_W'(BYTES - 1);
  assign funcField  = ADDR_W'(func) << FUNC_POS;
  assign busField   = ADDR_W'(bus) << BUS_POS;
  assign devField   = ADDR_W'(dev) << DEV_POS;

  always_comb begin
    if (isType0) begin
      winSel = T0_CODE | (idsel & WIN_MASK);
      addr   = CFG_BASE | (idsel & ~WIN_MASK) | funcField | offAligned;
    end else begin
      winSel = T1_CODE;
      addr   = CFG_BASE | busField | devField | funcField | offAligned;
    end
  end

  assign devBad = (cardbus && (dev != '0)) ||
                  (isType0 && (32'(dev) >= SLOT_MAX));

endmodule

// File: rtl/cfg_xlate_lane.sv
module cfg_xlate_lane #(
  parameter int DATA_W = 32,
  parameter int BYTES  = DATA_W / 8,
  parameter int LANE_W = $clog2(BYTES),
  parameter int LEN_W  = LANE_W + 1
) (
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANE_W-1:0] lane,
  input  logic [LEN_W-1:0]  len,
  output logic              lenBad,
  output logic [DATA_W-1:0] rdOut,
  output logic [DATA_W-1:0] merged
);

  localparam int SH_W  = LANE_W + 3;
  localparam int SUM_W = LEN_W + 1;

  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] fieldMask;
  logic              lenLegal;
  logic              straddle;

  assign shAmt   = {lane, 3'b000};
  assign shifted = word >> shAmt;

  always_comb begin
    if (len == LEN_W'(BYTES)) fieldMask = '1;
    else fieldMask = (DATA_W'(1) << {len, 3'b000}) - DATA_W'(1);
  end

  assign rdOut  = shifted & fieldMask;
  assign merged = (word & ~(fieldMask << shAmt)) | ((wdata & fieldMask) << shAmt);

  assign lenLegal = (len == LEN_W'(1)) || (len == LEN_W'(2)) || (len == LEN_W'(BYTES));
  assign straddle = (len != LEN_W'(BYTES)) &&
                    ((SUM_W'(lane) + SUM_W'(len)) > SUM_W'(BYTES));
  assign lenBad   = !lenLegal || straddle;

endmodule

// File: rtl/cfg_xlate_dp.sv
module cfg_xlate_dp
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int OFF_W     = 8,
  parameter int SLOT_MAX  = 16,
  parameter int IDSEL_POS = 16,
  parameter int BUS_POS   = 16,
  parameter int DEV_POS   = 11,
  parameter int FUNC_POS  = 8,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [ADDR_W-1:0] T0_CODE  = 32'h0000_0002,
  parameter logic [ADDR_W-1:0] T1_CODE  = 32'h0000_0003,
  parameter int BYTES  = DATA_W / 8,
  parameter int LANE_W = $clog2(BYTES),
  parameter int LEN_W  = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cardbusMode,
  input  logic [DATA_W-1:0] beRdata,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] winSelData,
  output logic [ADDR_W-1:0] beAddr,
  output logic [DATA_W-1:0] beWdata,
  output logic [DATA_W-1:0] rdData
);

  logic              capWrite;
  logic [BUS_W-1:0]  capBus;
  logic [DEV_W-1:0]  capDev;
  logic [FUNC_W-1:0] capFunc;
  logic [OFF_W-1:0]  capOff;
  logic [LEN_W-1:0]  capLen;
  logic [DATA_W-1:0] capWdata;
  logic              capCardbus;
  logic [DATA_W-1:0] wordReg;
  logic              errSeen;

  logic              devBad;
  logic              lenBad;
  logic [DATA_W-1:0] rdOut;
  logic [DATA_W-1:0] merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capWrite   <= 1'b0;
      capBus     <= '0;
      capDev     <= '0;
      capFunc    <= '0;
      capOff     <= '0;
      capLen     <= '0;
      capWdata   <= '0;
      capCardbus <= 1'b0;
      wordReg    <= '0;
      errSeen    <= 1'b0;
    end else begin
      if (strobe.capture) begin
        capWrite   <= reqWrite;
        capBus     <= reqBus;
        capDev     <= reqDev;
        capFunc    <= reqFunc;
        capOff     <= reqOff;
        capLen     <= reqLen;
        capWdata   <= reqWdata;
        capCardbus <= cardbusMode;
        errSeen    <= 1'b0;
      end else if (strobe.loadWord) begin
        wordReg <= strobe.errFill ? '1 : beRdata;
        errSeen <= strobe.errFill;
      end
    end
  end

  cfg_xlate_addr #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W),
    .OFF_W(OFF_W), .BYTES(BYTES), .SLOT_MAX(SLOT_MAX),
    .IDSEL_POS(IDSEL_POS), .BUS_POS(BUS_POS), .DEV_POS(DEV_POS),
    .FUNC_POS(FUNC_POS), .WIN_MASK(WIN_MASK), .CFG_BASE(CFG_BASE),
    .T0_CODE(T0_CODE), .T1_CODE(T1_CODE)
  ) addr_i (
    .bus(capBus), .dev(capDev), .func(capFunc), .off(capOff),
    .cardbus(capCardbus), .devBad(devBad), .winSel(winSelData), .addr(beAddr)
  );

  cfg_xlate_lane #(
    .DATA_W(DATA_W), .BYTES(BYTES), .LANE_W(LANE_W), .LEN_W(LEN_W)
  ) lane_i (
    .word(wordReg), .wdata(capWdata), .lane(capOff[LANE_W-1:0]),
    .len(capLen), .lenBad(lenBad), .rdOut(rdOut), .merged(merged)
  );

  assign status.invalid  = devBad || lenBad;
  assign status.isWrite  = capWrite;
  assign status.fullWord = (capLen == LEN_W'(BYTES));

  assign beWdata = status.fullWord ? capWdata : merged;

  always_comb begin
    if (errSeen) rdData = '1;
    else if (capWrite || status.invalid) rdData = '0;
    else rdData = rdOut;
  end

endmodule

// File: rtl/cfg_xlate_ctrl.sv
module cfg_xlate_ctrl
  import cfg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  dpStatus_t   status,
  input  logic        beAck,
  input  logic        beErr,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        doneValid,
  output logic [1:0]  doneErr,
  output logic        winSelWe,
  output logic        beReq,
  output logic        beWrite
);

  cfgState_t  state, stateNext;
  logic [1:0] errReg, errNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      errReg <= ERR_OK;
    end else begin
      state  <= stateNext;
      errReg <= errNext;
    end
  end

  always_comb begin
    stateNext = state;
    errNext   = errReg;
    strobe    = '0;
    winSelWe  = 1'b0;
    beReq     = 1'b0;
    beWrite   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.invalid) begin
          errNext   = ERR_INVAL;
          stateNext = ST_DONE;
        end else begin
          winSelWe  = 1'b1;
          errNext   = ERR_OK;
          stateNext = (status.isWrite && status.fullWord) ? ST_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        beReq = 1'b1;
        if (beAck) begin
          strobe.loadWord = 1'b1;
          strobe.errFill  = beErr;
          if (beErr) begin
            errNext   = ERR_BUS;
            stateNext = ST_DONE;
          end else begin
            stateNext = status.isWrite ? ST_WRITE : ST_DONE;
          end
        end
      end
      ST_WRITE: begin
        beReq   = 1'b1;
        beWrite = 1'b1;
        if (beAck) begin
          if (beErr) begin
            strobe.loadWord = 1'b1;
            strobe.errFill  = 1'b1;
            errNext         = ERR_BUS;
          end
          stateNext = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign doneValid = (state == ST_DONE);
  assign doneErr   = doneValid ? errReg : ERR_OK;

endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int OFF_W     = 8,
  parameter int SLOT_MAX  = 16,
  parameter int IDSEL_POS = 16,
  parameter int BUS_POS   = 16,
  parameter int DEV_POS   = 11,
  parameter int FUNC_POS  = 8,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [ADDR_W-1:0] T0_CODE  = 32'h0000_0002,
  parameter logic [ADDR_W-1:0] T1_CODE  = 32'h0000_0003,
  localparam int BYTES  = DATA_W / 8,
  localparam int LANE_W = $clog2(BYTES),
  localparam int LEN_W  = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cardbusMode,
  output logic              busy,
  output logic              doneValid,
  output logic [1:0]        doneErr,
  output logic [DATA_W-1:0] doneRdata,
  output logic              winSelWe,
  output logic [ADDR_W-1:0] winSelData,
  output logic              beReq,
  output logic              beWrite,
  output logic [ADDR_W-1:0] beAddr,
  output logic [DATA_W-1:0] beWdata,
  input  logic              beAck,
  input  logic              beErr,
  input  logic [DATA_W-1:0] beRdata
);

  ctrlStrobe_t       strobe;
  dpStatus_t         status;
  logic [DATA_W-1:0] rdData;

  cfg_xlate_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .status(status),
    .beAck(beAck), .beErr(beErr), .strobe(strobe), .busy(busy),
    .doneValid(doneValid), .doneErr(doneErr), .winSelWe(winSelWe),
    .beReq(beReq), .beWrite(beWrite)
  );

  cfg_xlate_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .DEV_W(DEV_W),
    .FUNC_W(FUNC_W), .OFF_W(OFF_W), .SLOT_MAX(SLOT_MAX),
    .IDSEL_POS(IDSEL_POS), .BUS_POS(BUS_POS), .DEV_POS(DEV_POS),
    .FUNC_POS(FUNC_POS), .WIN_MASK(WIN_MASK), .CFG_BASE(CFG_BASE),
    .T0_CODE(T0_CODE), .T1_CODE(T1_CODE), .BYTES(BYTES),
    .LANE_W(LANE_W), .LEN_W(LEN_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc), .reqOff(reqOff),
    .reqLen(reqLen), .reqWdata(reqWdata), .cardbusMode(cardbusMode),
    .beRdata(beRdata), .status(status), .winSelData(winSelData),
    .beAddr(beAddr), .beWdata(beWdata), .rdData(rdData)
  );

  assign doneRdata = doneValid ? rdData : '0;

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              doneValid,
  input logic [1:0]        doneErr,
  input logic [DATA_W-1:0] doneRdata,
  input logic              winSelWe,
  input logic              beReq,
  input logic              beWrite,
  input logic [ADDR_W-1:0] beAddr,
  input logic [DATA_W-1:0] beWdata,
  input logic              beAck,
  input logic              beErr
);

  logic touched;

  always_ff @(posedge clk) begin
    if (!rst_n) touched <= 1'b0;
    else if (!busy) touched <= 1'b0;
    else if (beReq || winSelWe) touched <= 1'b1;
  end

  // R11
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  // R11
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !busy);

  // R11
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> (doneErr != 2'd3));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beReq && !beAck) |=> (beReq && $stable(beAddr) && $stable(beWrite) && $stable(beWdata)));

  // R12
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beReq |-> (beAddr[1:0] == 2'b00));

  // R12
  win_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    winSelWe |-> (busy && !beReq));

  // R4
  inval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && doneErr == 2'd1) |-> !touched);

  // R10
  buserr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && doneErr == 2'd2) |-> (doneRdata == '1));

  // R10
  buserr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beReq && beAck && beErr) |=> !beReq);

endmodule

bind cfg_xlate cfg_xlate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/cfg_xlate_tb.sv
`timescale 1ns/1ps
module cfg_xlate_tb_top;

  localparam logic [31:0] BASE  = 32'h0C00_0000;
  localparam logic [31:0] MASK  = 32'hFC00_0000;
  localparam logic [31:0] T0    = 32'h0000_0002;
  localparam logic [31:0] T1    = 32'h0000_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [7:0]  reqOff = '0;
  logic [2:0]  reqLen = '0;
  logic [31:0] reqWdata = '0;
  logic        cardbusMode = 1'b0;
  logic        busy, doneValid, winSelWe, beReq, beWrite;
  logic [1:0]  doneErr;
  logic [31:0] doneRdata, winSelData, beAddr, beWdata;
  logic        beAck = 1'b0, beErr = 1'b0;
  logic [31:0] beRdata = '0;

  always #10 clk = ~clk;

  cfg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc), .reqOff(reqOff),
    .reqLen(reqLen), .reqWdata(reqWdata), .cardbusMode(cardbusMode),
    .busy(busy), .doneValid(doneValid), .doneErr(doneErr),
    .doneRdata(doneRdata), .winSelWe(winSelWe), .winSelData(winSelData),
    .beReq(beReq), .beWrite(beWrite), .beAddr(beAddr), .beWdata(beWdata),
    .beAck(beAck), .beErr(beErr), .beRdata(beRdata)
  );

  int nChecks = 0;
  int nFail = 0;

  // behavioural backend memory and logs
  logic [31:0] mem [logic [31:0]];
  bit          logW[$];
  logic [31:0] logA[$];
  logic [31:0] logD[$];
  logic [31:0] winLog[$];
  bit          errOn = 1'b0;
  logic [31:0] errAddr = '0;
  bit          mBusy = 1'b0;

  function automatic logic [31:0] memGet(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hC3A5_5A3C;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // backend responder
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (beAck) begin
        beAck = 1'b0;
        beErr = 1'b0;
      end else if (rst_n && beReq) begin
        if (waitCnt < int'(((beAddr >> 2) ^ (beAddr >> 8)) % 3)) waitCnt++;
        else begin
          bit hit;
          waitCnt = 0;
          hit     = errOn && (beAddr == errAddr);
          beAck   = 1'b1;
          beErr   = hit;
          beRdata = hit ? 32'hDEAD_BEEF : memGet(beAddr);
          logW.push_back(beWrite);
          logA.push_back(beAddr);
          logD.push_back(beWrite ? beWdata : 32'h0);
          if (beWrite && !hit) mem[beAddr] = beWdata;
        end
      end
    end
  end

  // window log and per-cycle busy model
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (winSelWe) winLog.push_back(winSelData);
        if (busy !== mBusy) chk(1'b0, "R11", "busy vs model", 32'(busy), 32'(mBusy));
        else nChecks++;
        if (doneValid) mBusy = 1'b0;
        else if (!mBusy && reqValid) mBusy = 1'b1;
      end else mBusy = 1'b0;
    end
  end

  // global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 32'h0, 32'h1);
    finishRun();
  end

  task automatic doReq(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                       input logic [2:0] func, input logic [7:0] off,
                       input logic [2:0] len, input logic [31:0] wd,
                       input string rq, input bit intrude);
    bit          bad;
    logic [63:0] oh;
    logic [31:0] win, addr, word, lmask, expRd, newWord;
    logic [1:0]  expErr;
    bit          hit;
    bit          eW[$];
    logic [31:0] eA[$];
    logic [31:0] eD[$];
    int          lane;
    bit          seen;

    // expected behaviour from the requirements
    lane  = int'(off[1:0]);
    bad   = !(len == 1 || len == 2 || len == 4) || (len == 2 && off[1:0] == 2'd3) ||
            (cardbusMode && dev != 0) || (bus == 0 && dev >= 16);
    oh    = 64'd1 << (16 + int'(dev));
    if (bus == 0) begin
      win  = T0 | (oh[31:0] & MASK);
      addr = BASE | (oh[31:0] & ~MASK) | (32'(func) << 8) | (32'(off) & ~32'd3);
    end else begin
      win  = T1;
      addr = BASE | (32'(bus) << 16) | (32'(dev) << 11) | (32'(func) << 8) | (32'(off) & ~32'd3);
    end
    lmask  = (len == 4) ? 32'hFFFF_FFFF : ((len == 2) ? 32'hFFFF : 32'hFF);
    word   = memGet(addr);
    hit    = errOn && (addr == errAddr);
    expRd  = 32'h0;
    expErr = 2'd0;
    if (bad) expErr = 2'd1;
    else if (!wr) begin
      eW.push_back(1'b0); eA.push_back(addr); eD.push_back(32'h0);
      if (hit) begin expErr = 2'd2; expRd = 32'hFFFF_FFFF; end
      else expRd = (word >> (8 * lane)) & lmask;
    end else if (len == 4) begin
      eW.push_back(1'b1); eA.push_back(addr); eD.push_back(wd);
      if (hit) begin expErr = 2'd2; expRd = 32'hFFFF_FFFF; end
    end else begin
      eW.push_back(1'b0); eA.push_back(addr); eD.push_back(32'h0);
      if (hit) begin expErr = 2'd2; expRd = 32'hFFFF_FFFF; end
      else begin
        newWord = (word & ~(lmask << (8 * lane))) | ((wd & lmask) << (8 * lane));
        eW.push_back(1'b1); eA.push_back(addr); eD.push_back(newWord);
      end
    end

    logW.delete(); logA.delete(); logD.delete(); winLog.delete();

    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBus = bus; reqDev = dev;
    reqFunc = func; reqOff = off; reqLen = len; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    if (intrude) begin
      reqValid = 1'b1; reqWrite = 1'b1; reqBus = 8'd9; reqDev = 5'd3;
      reqFunc = 3'd1; reqOff = 8'h80; reqLen = 3'd4; reqWdata = 32'h1234_5678;
      @(negedge clk);
      reqValid = 1'b0;
    end

    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (doneValid) seen = 1'b1;
    end
    chk(seen, rq, "done seen", 32'(seen), 32'h1);
    if (!seen) return;
    chk(doneErr === expErr, rq, "doneErr", 32'(doneErr), 32'(expErr));
    chk(doneRdata === expRd, rq, "doneRdata", doneRdata, expRd);

    // window register (R12)
    if (bad) chk(winLog.size() == 0, rq, "R12 no window write", winLog.size(), 0);
    else begin
      chk(winLog.size() == 1, "R12", "window write count", winLog.size(), 1);
      if (winLog.size() == 1) chk(winLog[0] === win, rq, "window value", winLog[0], win);
    end

    // backend accesses
    chk(logA.size() == eA.size(), rq, "access count", logA.size(), eA.size());
    if (logA.size() == eA.size()) begin
      for (int k = 0; k < eA.size(); k++) begin
        chk(logW[k] == eW[k], rq, "access dir", 32'(logW[k]), 32'(eW[k]));
        chk(logA[k] === eA[k], rq, "access addr", logA[k], eA[k]);
        chk(logD[k] === eD[k], rq, "access wdata", logD[k], eD[k]);
      end
    end

    if (intrude) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!doneValid, "R11", "no extra done", 32'(doneValid), 32'h0);
      end
      chk(logA.size() == eA.size(), "R11", "no extra access", logA.size(), eA.size());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", 32'(busy), 0);
    chk(doneValid == 1'b0, "R1", "doneValid", 32'(doneValid), 0);
    chk(beReq == 1'b0, "R1", "beReq", 32'(beReq), 0);
    chk(winSelWe == 1'b0, "R1", "winSelWe", 32'(winSelWe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 Type 1 reads, including a device above 15
    doReq(0, 8'd3, 5'd7, 3'd2, 8'h40, 3'd4, 0, "R3", 0);
    doReq(0, 8'd5, 5'd20, 3'd0, 8'h0C, 3'd4, 0, "R3", 0);
    // R2 Type 0, low device and high device (window bits)
    doReq(0, 8'd0, 5'd2, 3'd1, 8'h10, 3'd4, 0, "R2", 0);
    doReq(0, 8'd0, 5'd12, 3'd0, 8'h0D, 3'd1, 0, "R2", 0);
    doReq(0, 8'd0, 5'd15, 3'd7, 8'hFC, 3'd4, 0, "R2", 0);
    // R7 lane extraction
    doReq(0, 8'd1, 5'd4, 3'd3, 8'h06, 3'd2, 0, "R7", 0);
    doReq(0, 8'd1, 5'd4, 3'd3, 8'h07, 3'd1, 0, "R7", 0);
    doReq(0, 8'd1, 5'd4, 3'd3, 8'h05, 3'd2, 0, "R7", 0);
    // R8 sub-word writes, then read back
    doReq(1, 8'd2, 5'd1, 3'd0, 8'h21, 3'd1, 32'hFFFF_FFA5, "R8", 0);
    doReq(1, 8'd2, 5'd1, 3'd0, 8'h22, 3'd2, 32'h0000_BEEF, "R8", 0);
    doReq(0, 8'd2, 5'd1, 3'd0, 8'h20, 3'd4, 0, "R8", 0);
    doReq(1, 8'd0, 5'd3, 3'd0, 8'h04, 3'd2, 32'h0000_0006, "R8", 0);
    // R9 full-word write and read back
    doReq(1, 8'd6, 5'd9, 3'd5, 8'h30, 3'd4, 32'hCAFE_F00D, "R9", 0);
    doReq(0, 8'd6, 5'd9, 3'd5, 8'h30, 3'd4, 0, "R9", 0);
    // R4 device out of range on bus 0
    doReq(0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 0, "R4", 0);
    doReq(1, 8'd0, 5'd31, 3'd0, 8'h00, 3'd1, 32'h11, "R4", 0);
    // R5 cardbus restriction
    cardbusMode = 1'b1;
    doReq(0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd4, 0, "R5", 0);
    doReq(0, 8'd4, 5'd2, 3'd0, 8'h00, 3'd4, 0, "R5", 0);
    doReq(0, 8'd0, 5'd0, 3'd1, 8'h08, 3'd4, 0, "R5", 0);
    cardbusMode = 1'b0;
    // R6 length rules
    doReq(0, 8'd1, 5'd0, 3'd0, 8'h00, 3'd3, 0, "R6", 0);
    doReq(0, 8'd1, 5'd0, 3'd0, 8'h00, 3'd0, 0, "R6", 0);
    doReq(1, 8'd1, 5'd0, 3'd0, 8'h03, 3'd2, 32'h55, "R6", 0);
    doReq(0, 8'd1, 5'd0, 3'd0, 8'h03, 3'd1, 0, "R6", 0);
    // R10 bus errors: read, sub-word write, full write
    errOn = 1'b1;
    errAddr = BASE | (32'd7 << 16) | (32'd2 << 11) | 32'h44;
    doReq(0, 8'd7, 5'd2, 3'd0, 8'h46, 3'd1, 0, "R10", 0);
    doReq(1, 8'd7, 5'd2, 3'd0, 8'h45, 3'd1, 32'h77, "R10", 0);
    doReq(1, 8'd7, 5'd2, 3'd0, 8'h44, 3'd4, 32'h9999_0000, "R10", 0);
    errOn = 1'b0;
    // R11 request while busy is ignored
    doReq(0, 8'd8, 5'd6, 3'd2, 8'h18, 3'd4, 0, "R11", 1);
    doReq(1, 8'd0, 5'd5, 3'd1, 8'h1A, 3'd1, 32'h3C, "R11", 1);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule